// File: doc/BRIEF.md
# Duty-Coded Serial Word Transmitter

This block sends a fixed-length word on a single output wire by varying how long the wire is held high inside each bit cell. Every cell has the same period. A short high time marks a 0 and a high time twice as long marks a 1, and the wire stays low for the rest of the cell. A built-in cycle counter derives the cell timing from the system clock. At the defaults, with a 50 MHz clock, a cell is 125 cycles (2.5 µs, 400 kHz). A 0 is high for 25 cycles and a 1 is high for 50 cycles.

A parent places the word on `data_in` and pulses `start` for one cycle. The block captures the word and sends it least significant bit first. All cells go out back to back, with no stretched high or low time between them, because a pause inside a frame would corrupt it for the receiver. `busy` is high for the whole frame. When the last cell's low time has ended, `done` is high for one cycle and the wire returns to idle low. Frames are rare, so the wire spends most of its time idle.

Top module: `pwc_encoder`

## Requirements
- R1: While reset is held, and after it is released with no start, `line_out`, `busy` and `done` are all low.
- R2: A `start` sampled high while `busy` is low captures `data_in`. In the next cycle `busy` is high and `line_out` is high, beginning the first cell.
- R3: Within a frame, consecutive rising edges of `line_out` are exactly CELL_CYC cycles apart (125 at the defaults). The last cell also lasts CELL_CYC cycles, up to the fall of `busy`.
- R4: A data bit of value 0 holds `line_out` high for exactly ZERO_HI cycles (25) at the start of its cell.
- R5: A data bit of value 1 holds `line_out` high for exactly ONE_HI cycles (50) at the start of its cell.
- R6: Cell k of the frame carries bit k of the captured word, so bit 0 (the LSB) goes out first and bit NBITS-1 goes out last.
- R7: A frame has exactly NBITS cells (24), so `busy` stays high for exactly NBITS*CELL_CYC consecutive cycles (3000).
- R8: `done` is high for exactly one cycle, which is the first cycle with `busy` low after a frame. `done` is never high during a frame.
- R9: A `start` sampled while `busy` is high is ignored, including one in the frame's last cycle. The running frame keeps its word and timing, and no new frame follows.
- R10: A `start` sampled in the cycle where `done` is high begins a new frame in the next cycle, with no extra idle cycle.
- R11: Asserting `rst_n` low during a frame drives `line_out` and `busy` low at once and abandons the frame. No `done` follows.
- R12: `line_out` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset. Asserts asynchronously and is released synchronously inside the block |
| start | input | 1 | One-cycle request to send the word on `data_in` |
| data_in | input | NBITS | Word to send; captured only when a start is accepted |
| line_out | output | 1 | Duty-coded serial output; idles low |
| busy | output | 1 | High for the whole frame |
| done | output | 1 | One-cycle pulse after the final cell ends |

## Verification
Two events can fall in the same cycle: the end of one frame and a new start request. The bench provokes this in two ways. In the first, it raises `start` in the last busy cycle. That request must be dropped, so `busy` must stay low after the `done` pulse. In the second, it raises `start` in the cycle where `done` is high. That request must open a new frame in the very next cycle. In both cases the bench decodes every cell of the frame. It measures each high time and cell period in clock cycles and compares the decoded word with the one loaded.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  // Controller state: waiting for a request, or sending cells
  typedef enum logic {
    ENC_IDLE = 1'b0,
    ENC_SEND = 1'b1
  } enc_state_t;

endpackage

// File: rtl/pwc_reset_sync.sv
// Reset conditioner: asserts asynchronously, releases after STAGES clock edges.
module pwc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/pwc_cell_timer.sv
// Cycle counter that spans one bit cell and wraps in a single step.
module pwc_cell_timer #(
  parameter  int CELL_CYC = 125,
  localparam int CNT_W    = $clog2(CELL_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CELL_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_last;

  assign at_last = (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign last_o = at_last;

endmodule

// File: rtl/pwc_shifter.sv
// Holds the captured word, presents the current bit (LSB first), tracks the bit index.
module pwc_shifter #(
  parameter  int NBITS = 24,
  localparam int IDX_W = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [NBITS-1:0] data_i,
  output logic             bit_o,
  output logic             last_o
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NBITS - 1);

  logic [NBITS-1:0] word_q;
  logic [NBITS-1:0] word_d;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    word_d = word_q;
    idx_d  = idx_q;
    if (load) begin
      word_d = data_i;
      idx_d  = '0;
    end else if (shift) begin
      word_d = {1'b0, word_q[NBITS-1:1]};
      idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
    end else begin
      word_q <= word_d;
      idx_q  <= idx_d;
    end
  end

  assign bit_o  = word_q[0];
  assign last_o = (idx_q == IDX_LAST);

endmodule

// File: rtl/pwc_duty_gen.sv
// Compares the cell position with the high time chosen by the current bit.
module pwc_duty_gen #(
  parameter int CNT_W   = 7,
  parameter int ZERO_HI = 25,
  parameter int ONE_HI  = 50
) (
  input  logic             active,
  input  logic             bit_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             line_o
);

  localparam logic [CNT_W-1:0] HI_ZERO = CNT_W'(ZERO_HI);
  localparam logic [CNT_W-1:0] HI_ONE  = CNT_W'(ONE_HI);

  logic [CNT_W-1:0] hi_len;

  always_comb begin
    hi_len = bit_i ? HI_ONE : HI_ZERO;
    line_o = active && (cnt_i < hi_len);
  end

endmodule

// File: rtl/pwc_encoder.sv
module pwc_encoder
  import pwc_pkg::*;
#(
  parameter int NBITS      = 24,
  parameter int CELL_CYC   = 125,
  parameter int ZERO_HI    = 25,
  parameter int ONE_HI     = 50,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NBITS-1:0] data_in,
  output logic             line_out,
  output logic             busy,
  output logic             done
);

  localparam int CNT_W = $clog2(CELL_CYC);

  logic             rst_sync_n;
  enc_state_t       state_q;
  enc_state_t       state_d;
  logic             done_q;
  logic             done_d;
  logic             accept;
  logic             sending;
  logic             cell_last;
  logic             bit_last;
  logic             cur_bit;
  logic             frame_end;
  logic [CNT_W-1:0] cell_cnt;

  pwc_reset_sync #(
    .STAGES(RST_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n_async(rst_n),
    .rst_n_sync (rst_sync_n)
  );

  assign sending   = (state_q == ENC_SEND);
  assign accept    = (state_q == ENC_IDLE) && start;
  assign frame_end = sending && cell_last && bit_last;

  pwc_cell_timer #(
    .CELL_CYC(CELL_CYC)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (accept),
    .en    (sending),
    .cnt_o (cell_cnt),
    .last_o(cell_last)
  );

  pwc_shifter #(
    .NBITS(NBITS)
  ) u_shifter (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (accept),
    .shift (sending && cell_last),
    .data_i(data_in),
    .bit_o (cur_bit),
    .last_o(bit_last)
  );

  pwc_duty_gen #(
    .CNT_W  (CNT_W),
    .ZERO_HI(ZERO_HI),
    .ONE_HI (ONE_HI)
  ) u_duty (
    .active(sending),
    .bit_i (cur_bit),
    .cnt_i (cell_cnt),
    .line_o(line_out)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    unique case (state_q)
      ENC_IDLE: begin
        if (start) begin
          state_d = ENC_SEND;
        end
      end
      ENC_SEND: begin
        if (frame_end) begin
          state_d = ENC_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ENC_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ENC_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign busy = sending;
  assign done = done_q;

endmodule

// File: rtl/pwc_encoder_chk.sv
module pwc_encoder_chk #(
  parameter int NBITS    = 24,
  parameter int CELL_CYC = 125,
  parameter int ZERO_HI  = 25,
  parameter int ONE_HI   = 50
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic line_out
);

  localparam int TOTAL = NBITS * CELL_CYC;
  localparam int BW    = $clog2(TOTAL + 2);
  localparam int HW    = $clog2(ONE_HI + 2);

  logic [HW-1:0] hi_run;
  logic [BW-1:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run   <= '0;
      busy_run <= '0;
    end else begin
      if (!line_out) begin
        hi_run <= '0;
      end else if (hi_run != HW'(ONE_HI + 1)) begin
        hi_run <= hi_run + 1'b1;
      end
      busy_run <= busy ? busy_run + 1'b1 : '0;
    end
  end

  // R12
  idle_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_out);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && line_out));

  // R8
  done_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4 R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_out) |-> (hi_run == HW'(ZERO_HI) || hi_run == HW'(ONE_HI)));

  // R7
  frame_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == BW'(TOTAL)));

endmodule

bind pwc_encoder pwc_encoder_chk #(
  .NBITS   (NBITS),
  .CELL_CYC(CELL_CYC),
  .ZERO_HI (ZERO_HI),
  .ONE_HI  (ONE_HI)
) u_pwc_encoder_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .line_out(line_out)
);

// File: tb/test_pwc_encoder.sv
module test_pwc_encoder;

  localparam int NBITS = 24;
  localparam int CELL  = 125;
  localparam int ZHI   = 25;
  localparam int OHI   = 50;
  localparam int TOTAL = NBITS * CELL;

  logic             clk;
  logic             rst_n;
  logic             start;
  logic [NBITS-1:0] data_in;
  logic             line_out;
  logic             busy;
  logic             done;

  int n_chk  = 0;
  int n_fail = 0;

  // 250 MHz: 4-unit period
  initial clk = 1'b0;
  always #2 clk = ~clk;

  pwc_encoder #(
    .NBITS   (NBITS),
    .CELL_CYC(CELL),
    .ZERO_HI (ZHI),
    .ONE_HI  (OHI)
  ) i_pwc_encoder (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .data_in (data_in),
    .line_out(line_out),
    .busy    (busy),
    .done    (done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report_and_end;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Called at a negedge; returns at the negedge of the first busy cycle.
  task automatic drive_start(input logic [NBITS-1:0] w);
    start   = 1'b1;
    data_in = w;
    @(negedge clk);
    start   = 1'b0;
    data_in = ~w;
  endtask

  // Decodes one frame, measuring every pulse and cell in cycles.
  task automatic capture_frame(input logic [NBITS-1:0] exp_word, input int poke_at,
                               input logic [NBITS-1:0] poke_word, input bit chain,
                               input logic [NBITS-1:0] chain_word);
    int               cyc       = 0;
    int               hi_run    = 0;
    int               last_rise = -1;
    int               cells     = 0;
    int               bitn      = 0;
    logic             prev      = 1'b0;
    bit               poked     = 1'b0;
    logic [NBITS-1:0] got       = '0;
    check(busy && line_out, "R2", "busy and line high in first cycle", {busy, line_out}, 3);
    while (busy && cyc < TOTAL + 10) begin
      if (line_out && !prev) begin
        if (last_rise >= 0)
          check(cyc - last_rise == CELL, "R3", "cell period", cyc - last_rise, CELL);
        last_rise = cyc;
        cells++;
        hi_run = 0;
      end
      if (line_out) hi_run++;
      if (!line_out && prev && bitn < NBITS) begin
        if (exp_word[bitn])
          check(hi_run == OHI, "R5", "high time of a one", hi_run, OHI);
        else
          check(hi_run == ZHI, "R4", "high time of a zero", hi_run, ZHI);
        got[bitn] = (hi_run == OHI);
        bitn++;
      end
      if (done) check(1'b0, "R8", "done during frame", 1, 0);
      prev = line_out;
      if (poked) begin
        start = 1'b0;
        poked = 1'b0;
      end
      if (cyc == poke_at) begin
        start   = 1'b1;
        data_in = poke_word;
        poked   = 1'b1;
      end
      @(negedge clk);
      cyc++;
    end
    if (poked) start = 1'b0;
    check(cyc == TOTAL, "R7", "busy cycles", cyc, TOTAL);
    check(cells == NBITS, "R7", "cell count", cells, NBITS);
    check(cyc - last_rise == CELL, "R3", "last cell period", cyc - last_rise, CELL);
    check(got == exp_word, "R6", "decoded word (LSB first)", got, exp_word);
    check(done == 1'b1, "R8", "done after last cell", done, 1);
    check(line_out == 1'b0, "R12", "line idle low after frame", line_out, 0);
    if (chain) begin
      start   = 1'b1;
      data_in = chain_word;
      @(negedge clk);
      start   = 1'b0;
      data_in = '0;
      check(done == 1'b0, "R8", "done lasts one cycle", done, 0);
      check(busy == 1'b1, "R10", "frame restarts right after done", busy, 1);
    end else begin
      @(negedge clk);
      check(done == 1'b0, "R8", "done lasts one cycle", done, 0);
      check(busy == 1'b0, "R9", "no frame after ignored start", busy, 0);
      check(line_out == 1'b0, "R12", "line low while idle", line_out, 0);
    end
  endtask

  task automatic t_reset;
    rst_n   = 1'b0;
    start   = 1'b0;
    data_in = '0;
    repeat (3) @(negedge clk);
    check({line_out, busy, done} == 3'b000, "R1", "outputs during reset", {line_out, busy, done}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check({line_out, busy, done} == 3'b000, "R1", "outputs after release", {line_out, busy, done}, 0);
  endtask

  task automatic t_frame(input logic [NBITS-1:0] w);
    drive_start(w);
    capture_frame(w, -1, '0, 1'b0, '0);
    @(negedge clk);
  endtask

  task automatic t_ignore_start;
    // R9: mid-frame start with other data, then start in the last busy cycle
    drive_start(24'h3C5A96);
    capture_frame(24'h3C5A96, 1000, 24'hFFFFFF, 1'b0, '0);
    drive_start(24'h0F0F0F);
    capture_frame(24'h0F0F0F, TOTAL - 1, 24'hAAAAAA, 1'b0, '0);
    @(negedge clk);
  endtask

  task automatic t_chain;
    // R10: start raised in the done cycle
    drive_start(24'h123456);
    capture_frame(24'h123456, -1, '0, 1'b1, 24'hFEDCBA);
    capture_frame(24'hFEDCBA, -1, '0, 1'b0, '0);
    @(negedge clk);
  endtask

  task automatic t_mid_reset;
    bit saw_done = 1'b0;
    drive_start(24'hFFFFFF);
    repeat (700) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check({line_out, busy} == 2'b00, "R11", "reset stops frame at once", {line_out, busy}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done || busy || line_out) saw_done = 1'b1;
    end
    check(!saw_done, "R11", "no activity or done after abandoned frame", saw_done, 0);
    t_frame(24'h5A5A5A);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report_and_end();
  end

  initial begin
    rst_n   = 1'b0;
    start   = 1'b0;
    data_in = '0;
    @(negedge clk);
    t_reset();
    t_frame(24'hA5C3F0);
    t_frame(24'h000000);
    t_frame(24'hFFFFFF);
    t_frame(24'h000001);
    t_frame(24'h800000);
    t_ignore_start();
    t_chain();
    t_mid_reset();
    report_and_end();
  end

endmodule